// File: doc/BRIEF.md
# Dual-Channel Compare Toggle Output Timer

A free-running 16-bit up-counter advances once per count tick and feeds two compare channels. Each channel drives one output pin. While the counter runs and the channel is enabled, the pin inverts on every tick in which the counter equals that channel's compare value. A pin whose channel is disabled sits at a fixed idle level. When the counter is stopped, both pins sit at their idle levels. The idle level is the inverse of the channel's level-select bit.

Software sets the block up through a simple write port. One control word holds the run bit, the per-channel enable bits and the per-channel level-select bits. There is one compare word per channel. The count tick is a one-cycle enable on the system clock, so the block can be paced by any prescaler.

Top module: `toggle_timer_out`

## Requirements
- R1: After reset the counter is stopped and cleared, every compare value is zero, every enable and level-select bit is zero, and both pins are high.
- R2: While the run bit and a channel's enable bit are both 1, that channel's pin inverts on the clock edge of any cycle where the tick input is 1 and the counter equals the channel's compare value.
- R3: While a channel's enable bit is 0, its pin equals the inverse of its level-select bit, whatever the counter does. With level-select 0 the pin is high; with level-select 1 it is low.
- R4: While running, the counter adds one on each clock edge where tick is 1. It holds its value on edges where tick is 0, so no toggle can occur on those edges.
- R5: The counter wraps from 0xFFFF to 0x0000 and keeps counting, so a compare value of 0x0000 matches again after the wrap.
- R6: In the cycle after a control write with run = 0, both pins show their idle levels. By the following cycle the counter is cleared to 0x0000.
- R7: When a channel becomes enabled, or counting restarts with run = 1, the pin starts from its idle level. After a restart, counting begins at 0x0000.
- R8: If both compare values are equal and both channels are enabled, both pins invert on the same edge, each from its own present level.
- R9: A write at address 0 loads the control word: bit 0 is run, bits 1 and 2 are the enables of channels 0 and 1, and bits 3 and 4 are their level-select bits. Addresses 1 and 2 load compare values 0 and 1. A write at address 3 has no effect. A written value is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| tmr_out | output | 2 | Timer output pins, bit n for channel n |

## Verification
The assertions assume that tick and the write port are driven with clean levels that are stable around each clock edge. They also assume that software does not rely on a compare write taking effect in the same cycle as a tick. The bench changes inputs only at the falling edge. It never writes a compare register while the counter is running near the new value. Long runs with tick held high, and runs with tick gapped, cover counting, matches and wrap-around.

// File: rtl/toggle_timer_pkg.sv
package toggle_timer_pkg;
    parameter int CNT_W = 16;
    parameter int NCH   = 2;

    // control word bit layout
    localparam int RUN_BIT = 0;
    localparam int EN_LSB  = 1;
    localparam int LVL_LSB = EN_LSB + NCH;
    localparam int ADDR_W  = $clog2(NCH + 2);

    typedef struct packed {
        logic                      run;
        logic [NCH-1:0]            en;
        logic [NCH-1:0]            lvl;
        logic [NCH-1:0][CNT_W-1:0] cmp;
    } regs_t;
endpackage

// File: rtl/tt_counter.sv
module tt_counter
    import toggle_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick)
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q)); // R4
    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/tt_channel.sv
module tt_channel
    import toggle_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             lvl,
    output logic             pin
);
    logic tog_d, tog_q;
    logic hit;

    always_comb begin
        hit   = tick && (cnt == cmp);
        tog_d = act ? (tog_q ^ hit) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    // idle level is the inverse of the level-select bit
    assign pin = act ? (~lvl ^ tog_q) : ~lvl;

    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!act) |=> (tog_q == 1'b0)); // R7
    AST_TOGGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (act && hit) |=> (tog_q != $past(tog_q))); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !hit) |=> $stable(tog_q)); // R4
endmodule

// File: rtl/toggle_timer_out.sv
module toggle_timer_out
    import toggle_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    tmr_out
);
    regs_t            regs_d, regs_q;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == '0) begin
                regs_d.run = wr_data[RUN_BIT];
                regs_d.en  = wr_data[EN_LSB +: NCH];
                regs_d.lvl = wr_data[LVL_LSB +: NCH];
            end
            for (int i = 0; i < NCH; i++) begin
                if (int'(wr_addr) == i + 1)
                    regs_d.cmp[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    tt_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (regs_q.run),
        .tick  (tick),
        .cnt   (cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tt_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (regs_q.run && regs_q.en[g]),
            .tick  (tick),
            .cnt   (cnt),
            .cmp   (regs_q.cmp[g]),
            .lvl   (regs_q.lvl[g]),
            .pin   (tmr_out[g])
        );

        AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (!regs_q.run || !regs_q.en[g]) |-> (tmr_out[g] == ~regs_q.lvl[g])); // R3
    end

    AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) > NCH) |=> (regs_q == $past(regs_q))); // R9
endmodule

// File: tb/sim_toggle_timer_out.sv
module sim_toggle_timer_out;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  tmr_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // scoreboard queues
    logic [1:0] q_exp[$];
    string      q_tag[$];

    // reference state
    logic        m_run = 0;
    logic [1:0]  m_en = 0, m_lvl = 0, m_tog = 0;
    logic [15:0] m_cnt = 0;
    logic [15:0] m_cmp [2] = '{16'h0, 16'h0};

    always #2 clk = ~clk;

    toggle_timer_out u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .tmr_out(tmr_out)
    );

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: tmr_out=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: apply inputs for one cycle and push the expected post-edge pins
    task automatic step(input logic tk, input logic we, input logic [1:0] a,
                        input logic [15:0] d, input string tag);
        logic [1:0] e;
        @(negedge clk);
        tick = tk; wr_en = we; wr_addr = a; wr_data = d;
        for (int n = 0; n < 2; n++) begin
            logic h;
            h = tk && (m_cnt == m_cmp[n]);
            m_tog[n] = (m_run && m_en[n]) ? (m_tog[n] ^ h) : 1'b0;
        end
        m_cnt = m_run ? m_cnt + 16'(tk) : 16'h0;
        if (we) begin
            if (a == 2'd0) begin
                m_run = d[0]; m_en = d[2:1]; m_lvl = d[4:3];
            end else if (a == 2'd1) m_cmp[0] = d;
            else if (a == 2'd2)    m_cmp[1] = d;
        end
        for (int n = 0; n < 2; n++)
            e[n] = (m_run && m_en[n]) ? (~m_lvl[n] ^ m_tog[n]) : ~m_lvl[n];
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int cycles, input logic tk, input string tag);
        for (int i = 0; i < cycles; i++) step(tk, 1'b0, 2'd0, 16'h0, tag);
    endtask

    // monitor: pop and compare after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) check(tmr_out, q_exp.pop_front(), q_tag.pop_front());
        end
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: expired, actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tmr_out, 2'b11, "R1 reset pins high");
        rst_n = 1'b1;
        // R3: disabled channels follow level-select, stopped counter
        step(0, 1, 2'd0, 16'b01000, "R3 lvl0=1 idle low");
        step(0, 1, 2'd0, 16'b11001, "R3 running but disabled");
        idle(20, 1, "R3 disabled while counting");
        // R9: compare values, ignored address
        step(0, 1, 2'd1, 16'd5, "R9 cmp0 write");
        step(0, 1, 2'd2, 16'd9, "R9 cmp1 write");
        step(0, 1, 2'd0, 16'b00000, "R6 stop clears");
        idle(2, 0, "R6 stopped");
        // R2/R7: run both channels, mixed levels
        step(0, 1, 2'd0, 16'b10111, "R7 start from idle");
        idle(40, 1, "R2 toggling on match");
        step(0, 1, 2'd3, 16'h0000, "R9 addr3 ignored");
        idle(30, 1, "R9 after addr3 write");
        // R4: gapped ticks
        for (int i = 0; i < 30; i++) step(logic'(i % 3 == 0), 1'b0, 2'd0, 16'h0, "R4 gapped tick");
        // R3: disable channel 1 mid run
        step(0, 1, 2'd0, 16'b10011, "R3 disable ch1");
        idle(25, 1, "R3 ch1 disabled");
        step(0, 1, 2'd0, 16'b10111, "R7 re-enable ch1");
        idle(25, 1, "R7 ch1 from idle");
        // R6: stop and restart
        step(0, 1, 2'd0, 16'b10110, "R6 stop to idle");
        idle(3, 1, "R6 stopped ticks");
        step(0, 1, 2'd0, 16'b00111, "R7 restart at zero");
        idle(20, 1, "R7 restart counting");
        // R8: equal compares
        step(0, 1, 2'd0, 16'b00000, "R6 stop");
        step(0, 1, 2'd1, 16'd7, "R8 cmp0");
        step(0, 1, 2'd2, 16'd7, "R8 cmp1");
        step(0, 1, 2'd0, 16'b01111, "R8 start");
        idle(20, 1, "R8 both toggle together");
        // R5: wrap
        step(0, 1, 2'd0, 16'b00000, "R6 stop");
        step(0, 1, 2'd1, 16'hFFFF, "R5 cmp0 top");
        step(0, 1, 2'd2, 16'h0000, "R5 cmp1 zero");
        step(0, 1, 2'd0, 16'b00111, "R5 start");
        idle(65545, 1, "R5 wrap match");
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule